// File: doc/BRIEF.md
# Line-Change Timestamp Recorder

This block watches a parameterised set of single-bit lines, such as general-purpose pins or interrupt request wires, and notes every change of level on the lines that software has armed. Each input passes through a two-flop synchroniser before a change is detected. When an armed line changes, the block takes the current value of a shared free-running time counter, which arrives on the `sys_time` input, and queues an entry. The entry holds that time value, the numeric line number and the level the line moved to.

Lines are armed through a bitmap of 32-bit words, one word per group of 32 lines. Line number L lives in word L/32 at bit L%32. Changes on several lines in the same cycle are queued one per cycle, lowest line number first. The queue drives a level interrupt while its fill is at or above a programmable count. Software peeks at the oldest entry through a small word-addressed register port and removes it by reading the info word. When the queue is full, new entries are dropped and a sticky flag records the loss.

Top module: `lte_engine`

## Requirements
- R1: After reset the fill count is 0, `irq` is 0, the overflow flag is 0, the threshold reads 1 and every arm word reads 0.
- R2: A level change on an armed line, presented before clock edge c, is recorded with the `sys_time` value sampled at edge c+2 and becomes readable after edge c+3. The entry carries the line number and the new level.
- R3: A change on an unarmed line creates no entry, and arming a line whose level changed while it was unarmed creates no entry.
- R4: Word address 8+k holds the arm bits of lines 32k to 32k+31, with line L at bit L%32. A write there takes effect on the next edge and reads back unchanged.
- R5: Changes on several armed lines in the same cycle are queued in ascending line-number order, one per cycle, all with the same time value.
- R6: The register port is word addressed. Address 0 is status: fill in [15:0], `irq` at bit 30, overflow at bit 31. Address 1 is the threshold. Address 2 holds time bits [31:0] and address 3 holds time bits [63:32] of the oldest entry. Address 4 is info: line number in [15:0], level at bit 16, a not-empty flag at bit 31. A read strobe at address 4 removes the oldest entry. The same strobe on an empty queue changes nothing and returns bit 31 as 0.
- R7: `irq` is high exactly while the fill is at or above the threshold, and it drops on the edge at which a removal brings the fill below the threshold.
- R8: Writes to the threshold are clamped into 1 to 256: 0 is stored as 1, and values above 256 are stored as 256.
- R9: An entry that arrives while the queue is full is dropped and sets the overflow flag. The flag stays set until a status write with bit 31 at 1.
- R10: Disarming a line discards its queued-but-not-yet-stored change, so that change never reaches the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_in | input | NUM_SLICES*32 | Monitored lines, asynchronous |
| sys_time | input | TS_W | Shared free-running time counter |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes an entry at address 4) |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Fill-threshold interrupt level |

## Verification
Several results arrive at different times. A line change shows up in the queue after the third edge following the change: two synchroniser stages, then the pending stage, then the queue write. Its time value is the counter sampled two edges after the change. A burst of n simultaneous changes completes n-1 edges later. Register writes, entry removals and the `irq` reaction all take one edge. The bench drives every stimulus on a falling edge, waits exactly the number of falling edges these latencies give, and then samples; read data is taken one time unit after the address settles.

// File: rtl/lte_pkg.sv
package lte_pkg;
   localparam int unsigned SLICE_W    = 32;
   localparam int unsigned REG_STATUS = 0;
   localparam int unsigned REG_THRESH = 1;
   localparam int unsigned REG_TS_LO  = 2;
   localparam int unsigned REG_TS_HI  = 3;
   localparam int unsigned REG_INFO   = 4;
   localparam int unsigned REG_SLICE0 = 8;
   localparam int unsigned THR_MAX    = 256;
   localparam int unsigned THR_W      = 9;
   localparam int unsigned OVF_BIT    = 31;
   localparam int unsigned IRQ_BIT    = 30;
   localparam int unsigned VALID_BIT  = 31;
   localparam int unsigned LEVEL_BIT  = 16;

   // Bring a written threshold into the legal window 1..THR_MAX.
   function automatic logic [THR_W-1:0] clamp_thr(input logic [31:0] v);
      if (v == 32'd0)
         return THR_W'(1);
      else if (v > THR_MAX)
         return THR_W'(THR_MAX);
      else
         return v[THR_W-1:0];
   endfunction
endpackage

// File: rtl/lte_line_watch.sv
module lte_line_watch #(
   parameter int unsigned LINES = 96,
   parameter int unsigned TS_W  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lines_in,
   input  logic [LINES-1:0] en,
   input  logic [LINES-1:0] grant,
   input  logic [TS_W-1:0]  sys_time,
   output logic [LINES-1:0] pend,
   output logic [LINES-1:0] lvl,
   output logic [TS_W-1:0]  stamp [LINES]
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic            s1_q, s2_q, prev_q, pend_q, lvl_q;
      logic [TS_W-1:0] stamp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            prev_q  <= 1'b0;
            pend_q  <= 1'b0;
            lvl_q   <= 1'b0;
            stamp_q <= '0;
         end else begin
            s1_q   <= lines_in[i];
            s2_q   <= s1_q;
            prev_q <= s2_q;          // tracked even while disarmed
            if (!en[i]) begin
               pend_q <= 1'b0;       // disarm drops a waiting change
            end else if (s2_q != prev_q) begin
               pend_q  <= 1'b1;
               lvl_q   <= s2_q;
               stamp_q <= sys_time;
            end else if (grant[i]) begin
               pend_q <= 1'b0;
            end
         end
      end

      assign pend[i]  = pend_q;
      assign lvl[i]   = lvl_q;
      assign stamp[i] = stamp_q;
   end
endmodule

// File: rtl/lte_pick_low.sv
module lte_pick_low #(
   parameter int unsigned N = 96,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             valid
);
   assign valid = |req;
   assign grant = req & (~req + N'(1));

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/lte_fifo.sv
module lte_fifo #(
   parameter int unsigned W     = 72,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] fill,
   output logic             full,
   output logic             empty
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("lte_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr, wnext, rnext;
   logic             do_push, do_pop;

   assign full    = (fill == CNT_W'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wnext = wptr + PTR_W'(1);
      assign rnext = rptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wnext = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + PTR_W'(1);
      assign rnext = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + CNT_W'(1);
            2'b01:   fill <= fill - CNT_W'(1);
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/lte_engine.sv
module lte_engine
   import lte_pkg::*;
#(
   parameter int unsigned NUM_SLICES = 3,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned TS_W       = 64,
   parameter int unsigned ADDR_W     = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_SLICES*SLICE_W-1:0]    lines_in,
   input  logic [TS_W-1:0]                  sys_time,
   input  logic                             reg_wr,
   input  logic                             reg_rd,
   input  logic [ADDR_W-1:0]                reg_addr,
   input  logic [31:0]                      reg_wdata,
   output logic [31:0]                      reg_rdata,
   output logic                             irq
);
   localparam int unsigned LINES = NUM_SLICES * SLICE_W;
   localparam int unsigned ID_W  = $clog2(LINES);
   localparam int unsigned ENT_W = 1 + ID_W + TS_W;
   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

   if (NUM_SLICES < 1) begin : g_bad_slices
      $error("lte_engine: NUM_SLICES must be at least 1");
   end
   if (TS_W <= 32 || TS_W > 64) begin : g_bad_ts
      $error("lte_engine: TS_W must lie in 33..64");
   end
   if (ID_W > 16 || CNT_W > 16) begin : g_bad_fields
      $error("lte_engine: line number or fill does not fit its 16-bit field");
   end
   if (REG_SLICE0 + NUM_SLICES > (1 << ADDR_W)) begin : g_bad_addr
      $error("lte_engine: ADDR_W too narrow for the arm words");
   end

   // ---------------- arm bitmap ----------------
   logic [SLICE_W-1:0] en_q [NUM_SLICES];
   logic [LINES-1:0]   en_flat;

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      logic hit;
      assign hit = reg_wr && (reg_addr == ADDR_W'(REG_SLICE0 + k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   en_q[k] <= '0;
         else if (hit) en_q[k] <= reg_wdata;
      end
      assign en_flat[k*SLICE_W +: SLICE_W] = en_q[k];
   end

   // ---------------- change detection and ordering ----------------
   logic [LINES-1:0] pend, lvl, grant;
   logic [TS_W-1:0]  stamp [LINES];
   logic [ID_W-1:0]  sel_id;
   logic             sel_valid;

   lte_line_watch #(.LINES(LINES), .TS_W(TS_W)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_in (lines_in),
      .en       (en_flat),
      .grant    (grant),
      .sys_time (sys_time),
      .pend     (pend),
      .lvl      (lvl),
      .stamp    (stamp)
   );

   lte_pick_low #(.N(LINES)) u_pick (
      .req   (pend),
      .grant (grant),
      .idx   (sel_id),
      .valid (sel_valid)
   );

   // ---------------- entry queue ----------------
   logic [ENT_W-1:0] ent_in, ent_out;
   logic [CNT_W-1:0] fill;
   logic             full, empty, pop;

   assign ent_in = {lvl[sel_id], sel_id, stamp[sel_id]};
   assign pop    = reg_rd && (reg_addr == ADDR_W'(REG_INFO)) && !empty;

   lte_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (sel_valid),
      .pop   (pop),
      .din   (ent_in),
      .dout  (ent_out),
      .fill  (fill),
      .full  (full),
      .empty (empty)
   );

   // ---------------- control registers ----------------
   logic             ovf_q;
   logic [THR_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         thr_q <= THR_W'(1);
      end else begin
         if (sel_valid && full)
            ovf_q <= 1'b1;
         else if (reg_wr && reg_addr == ADDR_W'(REG_STATUS) && reg_wdata[OVF_BIT])
            ovf_q <= 1'b0;
         if (reg_wr && reg_addr == ADDR_W'(REG_THRESH))
            thr_q <= clamp_thr(reg_wdata);
      end
   end

   assign irq = (32'(fill) >= 32'(thr_q));

   // ---------------- read mux ----------------
   logic [63:0]     head_ts;
   logic [ID_W-1:0] head_id;
   logic            head_lvl;

   assign head_ts  = 64'(ent_out[TS_W-1:0]);
   assign head_id  = ent_out[TS_W +: ID_W];
   assign head_lvl = ent_out[ENT_W-1];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(REG_STATUS)) begin
         reg_rdata[15:0]    = 16'(fill);
         reg_rdata[IRQ_BIT] = irq;
         reg_rdata[OVF_BIT] = ovf_q;
      end else if (reg_addr == ADDR_W'(REG_THRESH)) begin
         reg_rdata = 32'(thr_q);
      end else if (reg_addr == ADDR_W'(REG_TS_LO)) begin
         reg_rdata = head_ts[31:0];
      end else if (reg_addr == ADDR_W'(REG_TS_HI)) begin
         reg_rdata = head_ts[63:32];
      end else if (reg_addr == ADDR_W'(REG_INFO)) begin
         if (!empty) begin
            reg_rdata[15:0]      = 16'(head_id);
            reg_rdata[LEVEL_BIT] = head_lvl;
            reg_rdata[VALID_BIT] = 1'b1;
         end
      end else begin
         for (int k = 0; k < NUM_SLICES; k++) begin
            if (reg_addr == ADDR_W'(REG_SLICE0 + k)) reg_rdata = en_q[k];
         end
      end
   end
endmodule

// File: rtl/lte_engine_chk.sv
module lte_engine_chk #(
   parameter int unsigned LINES  = 96,
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic [CNT_W-1:0]  fill,
   input logic [8:0]        thr,
   input logic              ovf,
   input logic [LINES-1:0]  grant,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata
);
   // R7: an empty queue never raises the interrupt (threshold is at least 1)
   a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0) |-> !irq);

   // R8: stored threshold always inside 1..256
   a_r8_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
      (thr >= 9'd1) && (thr <= 9'd256));

   // R9: fill never passes the queue depth
   a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fill) <= DEPTH);

   // R9: overflow flag is sticky until a clearing status write
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(reg_wr && reg_addr == '0 && reg_wdata[31])) |=> ovf);

   // R5: at most one line is served per cycle
   a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R5: fill moves by at most one entry per cycle
   a_r5_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == $past(fill)) || (fill == $past(fill) + CNT_W'(1)) ||
      (fill + CNT_W'(1) == $past(fill)));
endmodule

bind lte_engine lte_engine_chk #(
   .LINES(LINES), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .fill      (fill),
   .thr       (thr_q),
   .ovf       (ovf_q),
   .grant     (grant),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata)
);

// File: tb/lte_engine_test.sv
module lte_engine_test;
   localparam int NL = 96;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] lines = '0;
   logic [63:0]   sys_time = 64'd0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [5:0]    addr = '0;
   logic [31:0]   wdata = '0, rdata;
   logic          irq;

   int n_run = 0, n_fail = 0;
   logic [63:0] t0;
   bit done = 0;

   always #10 clk = ~clk;                     // 50 MHz
   always @(posedge clk) sys_time <= sys_time + 64'd1;

   lte_engine uut (
      .clk(clk), .rst_n(rst_n), .lines_in(lines), .sys_time(sys_time),
      .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq(irq)
   );

   // table walked by the main loop: line numbers to toggle one at a time
   localparam int VEC_N = 6;
   localparam int VEC_ID [VEC_N] = '{0, 31, 32, 95, 5, 64};

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic peek(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic pop_entry(output logic [63:0] ts, output logic [31:0] info);
      logic [31:0] lo, hi;
      @(negedge clk);
      addr = 6'd2; #1 lo = rdata;
      addr = 6'd3; #1 hi = rdata;
      addr = 6'd4; rd = 1'b1; #1 info = rdata;
      @(negedge clk);
      rd = 1'b0;
      ts = {hi, lo};
   endtask

   task automatic toggle(input logic [NL-1:0] mask);
      @(negedge clk);
      lines = lines ^ mask;
      t0 = sys_time;
   endtask

   function automatic logic [NL-1:0] bit_of(input int id);
      return {{(NL-1){1'b0}}, 1'b1} << id;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d, info;
      logic [63:0] ts;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      peek(6'd0, d); check("R1 status", 64'(d), 64'h0);
      peek(6'd1, d); check("R1 threshold", 64'(d), 64'd1);
      peek(6'd8, d); check("R1 arm word 0", 64'(d), 64'h0);
      check("R1 irq", 64'(irq), 64'd0);

      // R3 disarmed line is ignored; arming later gives no stale entry
      toggle(bit_of(7)); idle(4);
      peek(6'd0, d); check("R3 disarmed change", 64'(d[15:0]), 64'd0);
      for (int k = 0; k < 3; k++) wr_reg(6'(8 + k), 32'hFFFF_FFFF);
      idle(4);
      peek(6'd0, d); check("R3 arm after change", 64'(d[15:0]), 64'd0);
      peek(6'd9, d); check("R4 arm readback", 64'(d), 64'hFFFF_FFFF);

      // R2/R4 table of single-line changes
      for (int v = 0; v < VEC_N; v++) begin
         toggle(bit_of(VEC_ID[v])); idle(4);
         pop_entry(ts, info);
         check("R2 line number", 64'(info[15:0]), 64'(VEC_ID[v]));
         check("R2 level", 64'(info[16]), 64'(lines[VEC_ID[v]]));
         check("R2 time value", ts, t0 + 64'd2);
      end

      // R5 simultaneous changes
      toggle(bit_of(70) | bit_of(3) | bit_of(40)); idle(6);
      peek(6'd0, d); check("R5 fill", 64'(d[15:0]), 64'd3);
      pop_entry(ts, info); check("R5 first", 64'(info[15:0]), 64'd3);
      check("R5 same time", ts, t0 + 64'd2);
      pop_entry(ts, info); check("R5 second", 64'(info[15:0]), 64'd40);
      pop_entry(ts, info); check("R5 third", 64'(info[15:0]), 64'd70);
      check("R5 same time last", ts, t0 + 64'd2);

      // R6 removal from empty queue
      pop_entry(ts, info); check("R6 empty valid bit", 64'(info[31]), 64'd0);
      peek(6'd0, d); check("R6 empty fill", 64'(d[15:0]), 64'd0);

      // R7 threshold interrupt
      wr_reg(6'd1, 32'd3);
      toggle(bit_of(9)); idle(4);
      toggle(bit_of(10)); idle(4);
      check("R7 below threshold", 64'(irq), 64'd0);
      toggle(bit_of(11)); idle(4);
      check("R7 at threshold", 64'(irq), 64'd1);
      peek(6'd0, d); check("R7 status irq bit", 64'(d[30]), 64'd1);
      pop_entry(ts, info);
      check("R7 drops after removal", 64'(irq), 64'd0);
      pop_entry(ts, info); pop_entry(ts, info);

      // R8 clamping
      wr_reg(6'd1, 32'd0);   peek(6'd1, d); check("R8 zero", 64'(d), 64'd1);
      wr_reg(6'd1, 32'd300); peek(6'd1, d); check("R8 large", 64'(d), 64'd256);
      wr_reg(6'd1, 32'd1);

      // R9 overflow
      toggle({{(NL-17){1'b0}}, 17'h1FFFF}); idle(22);
      peek(6'd0, d);
      check("R9 fill at depth", 64'(d[15:0]), 64'd16);
      check("R9 overflow set", 64'(d[31]), 64'd1);
      wr_reg(6'd0, 32'h0);
      peek(6'd0, d); check("R9 flag sticky", 64'(d[31]), 64'd1);
      wr_reg(6'd0, 32'h8000_0000);
      peek(6'd0, d); check("R9 flag cleared", 64'(d[31]), 64'd0);
      for (int k = 0; k < 16; k++) begin
         pop_entry(ts, info);
         if (k == 15) check("R9 last kept line", 64'(info[15:0]), 64'd15);
      end

      // R10 disarm discards a waiting change
      toggle(bit_of(0) | bit_of(1) | bit_of(2) | bit_of(3) | bit_of(50));
      idle(3);
      wr_reg(6'd9, 32'h0);
      idle(6);
      peek(6'd0, d); check("R10 waiting change dropped", 64'(d[15:0]), 64'd4);
      for (int k = 0; k < 4; k++) pop_entry(ts, info);
      check("R10 last stored line", 64'(info[15:0]), 64'd3);
      wr_reg(6'd9, 32'hFFFF_FFFF); idle(4);
      peek(6'd0, d); check("R10 no entry on rearm", 64'(d[15:0]), 64'd0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule